// File: doc/BRIEF.md
# Indirect Configuration and I/O Access Port

This block is the register front end that a host CPU uses to reach PCI configuration space and PCI I/O space through a small memory-mapped window. Software first writes a target address into an address register. It then reads or writes one of two data ports. The configuration-data port turns the access into a downstream configuration request. The I/O-data port turns it into a downstream I/O request, and it reverses the byte order of multi-byte values, because the CPU side is big-endian and the PCI side is little-endian. The window also holds a few side registers: a fast-back-to-back enable, a TOC target address, an arbitration mask and a latency timer. Some of their bits are hardwired or forced.

Each CPU access carries a byte address and a size of 1, 2 or 4 bytes. The block checks whether that offset and size are legal for the target register. An illegal access gets an error response. It changes no state and sends nothing downstream. A data-port write is posted and is answered at once. A data-port read waits for the downstream side to return data, and the block accepts no new access until that data arrives. Carrying out the PCI cycles themselves is left to the logic behind the downstream interface.

Top module: `cfgio_port`

## Requirements
- R1: A 4-byte write to the address register (byte offset 0x00) stores all 32 bits, and a 4-byte read returns that raw value unchanged, including its two low bits.
- R2: Any other size, or any non-zero byte offset, on the address register gets an error response and leaves the stored value as it was.
- R3: A legal configuration-data access (offsets 0x04 to 0x07) issues one downstream request with dn_io=0. Its address is the stored address with bits 1:0 replaced by the access offset bits 1:0, and its data is passed with no byte reordering.
- R4: On both data ports, size code 0 (1 byte) is legal at every offset, code 1 (2 bytes) only at offsets 0 and 2, and code 2 (4 bytes) only at offset 0. Code 3 and every other combination get an error response and no downstream request. The I/O-data port is at offsets 0x08 to 0x0B, and addresses from 0x1C upward are unmapped and always give an error.
- R5: On the I/O-data port, 2-byte and 4-byte values are byte-reversed in both directions between the CPU value and the downstream value. 1-byte values pass through as they are. All data is right-justified, and unused upper bytes are zero.
- R6: A write to the fast-back-to-back register (0x0C) keeps only data bits 1:0, and a read returns them with all other bits zero.
- R7: The TOC register (0x10) resets to 0xFFFA0030. A write stores 0xFFFA0030 ORed with data bits 16:13.
- R8: Bit 0 of the arbitration mask (0x14) and bits 2:0 of the latency timer (0x18) always read as zero. All their other bits read back as written.
- R9: Register accesses, error responses and data-port writes are answered one cycle after they are accepted, and a data-port write raises dn_valid in that same cycle. A data-port read raises dn_valid one cycle after acceptance, holds cpu_ready low until dn_done, and is answered one cycle after dn_done.
- R10: After reset, the address register, the fast-back-to-back register, the arbitration mask and the latency timer all read as zero, and cpu_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | Block can accept an access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW (8) | Byte address inside the window |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| cpu_wdata | input | DW (32) | Right-justified write value |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Access was illegal |
| rsp_rdata | output | DW (32) | Right-justified read value |
| dn_valid | output | 1 | Downstream request pulse |
| dn_io | output | 1 | 1 = I/O cycle, 0 = configuration cycle |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream byte address |
| dn_size | output | 2 | Downstream size code, same encoding as cpu_size |
| dn_wdata | output | DW (32) | Downstream write value, PCI byte order |
| dn_done | input | 1 | Downstream read data is valid |
| dn_rdata | input | DW (32) | Downstream read value, PCI byte order |

## Verification
The bench runs every combination of offset, size code and direction on both data ports. This catches a legality table that accepts a misaligned 2-byte access at offset 1 or 3, or a size-3 access. It also catches a decoder that still sends a request after it flags an error. The bench checks the downstream address against a stored address whose two low bits are set, so a design that forwards those bits instead of the access offset shows up. It sends asymmetric byte patterns through the I/O port in both directions, which exposes a missing reversal, a reversal applied to the configuration port, or a 2-byte reversal that uses the wrong byte pair. The side registers are written with all ones, so any forced or hardwired bit that the design lets through appears in the readback.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;

  localparam logic [1:0] SZ1 = 2'd0;
  localparam logic [1:0] SZ2 = 2'd1;
  localparam logic [1:0] SZ4 = 2'd2;

  typedef enum logic [2:0] {
    RG_CADDR,
    RG_CDATA,
    RG_IODATA,
    RG_FBB,
    RG_TOC,
    RG_ARB,
    RG_LAT,
    RG_NONE
  } region_e;

  localparam logic [31:0] TOC_BASE = 32'hFFFA_0030;
  localparam logic [31:0] TOC_KEEP = 32'h0001_E000;
  localparam logic [31:0] ARB_ZERO = 32'h0000_0001;
  localparam logic [31:0] LAT_ZERO = 32'h0000_0007;

endpackage

// File: rtl/cfgio_decode.sv
module cfgio_decode
  import cfgio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output region_e       region,
  output logic          legal,
  output logic          is_data
);
  localparam int WW = AW - 2;

  logic [WW-1:0] word;
  logic [1:0]    off;
  logic          natural_ok;
  logic          full_word_ok;

  assign word = addr[AW-1:2];
  assign off  = addr[1:0];

  always_comb begin
    case (word)
      WW'(0):  region = RG_CADDR;
      WW'(1):  region = RG_CDATA;
      WW'(2):  region = RG_IODATA;
      WW'(3):  region = RG_FBB;
      WW'(4):  region = RG_TOC;
      WW'(5):  region = RG_ARB;
      WW'(6):  region = RG_LAT;
      default: region = RG_NONE;
    endcase
  end

  // Data ports follow natural alignment: any byte, even halfword, offset-0 word.
  assign natural_ok   = (size == SZ1) ||
                        (size == SZ2 && !off[0]) ||
                        (size == SZ4 && off == 2'd0);
  assign full_word_ok = (size == SZ4) && (off == 2'd0);
  assign is_data      = (region == RG_CDATA) || (region == RG_IODATA);

  always_comb begin
    if (region == RG_NONE) legal = 1'b0;
    else if (is_data)      legal = natural_ok;
    else                   legal = full_word_ok;
  end
endmodule

// File: rtl/cfgio_lanes.sv
module cfgio_lanes
  import cfgio_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  logic [1:0]    size,
  input  logic          swap,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;

  generate
    for (genvar i = 0; i < NB; i++) begin : g_byte
      localparam int R2 = (i < 2) ? (1 - i) : 0;
      localparam int R4 = (i < 4) ? (3 - i) : 0;
      logic [7:0] b;
      always_comb begin
        b = 8'h00;
        case (size)
          SZ1: if (i == 0) b = din[7:0];
          SZ2: if (i < 2)  b = swap ? din[8*R2 +: 8] : din[8*i +: 8];
          SZ4: if (i < 4)  b = swap ? din[8*R4 +: 8] : din[8*i +: 8];
          default: b = 8'h00;
        endcase
      end
      assign dout[8*i +: 8] = b;
    end
  endgenerate
endmodule

// File: rtl/cfgio_regs.sv
module cfgio_regs
  import cfgio_pkg::*;
#(
  parameter int DW  = 32,
  parameter int DAW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  region_e        region,
  input  logic [DW-1:0]  wdata,
  output logic [DAW-1:0] addr_raw,
  output logic [DW-1:0]  rd_data
);
  logic [1:0]    fbb_q;
  logic [31:0]   toc_q;
  logic [DW-1:0] arb_q;
  logic [DW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_raw <= '0;
      fbb_q    <= '0;
      toc_q    <= TOC_BASE;
      arb_q    <= '0;
      lat_q    <= '0;
    end else if (wr_en) begin
      case (region)
        RG_CADDR: addr_raw <= wdata[DAW-1:0];
        RG_FBB:   fbb_q    <= wdata[1:0];
        RG_TOC:   toc_q    <= TOC_BASE | (wdata[31:0] & TOC_KEEP);
        RG_ARB:   arb_q    <= wdata;
        RG_LAT:   lat_q    <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (region)
      RG_CADDR: rd_data = DW'(addr_raw);
      RG_FBB:   rd_data = DW'(fbb_q);
      RG_TOC:   rd_data = DW'(toc_q);
      RG_ARB:   rd_data = arb_q & ~DW'(ARB_ZERO);
      RG_LAT:   rd_data = lat_q & ~DW'(LAT_ZERO);
      default:  rd_data = '0;
    endcase
  end

  // R7: only bits 16:13 may leave the fixed TOC pattern
  a_r7_toc_pattern: assert property (@(posedge clk) disable iff (rst)
    (toc_q | TOC_KEEP) == (TOC_BASE | TOC_KEEP));

  // R1: a write to the address register lands unaltered
  a_r1_raw_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == RG_CADDR) |=> addr_raw == $past(wdata[DAW-1:0]));
endmodule

// File: rtl/cfgio_port.sv
module cfgio_port
  import cfgio_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int DAW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpu_valid,
  output logic           cpu_ready,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [1:0]     cpu_size,
  input  logic [DW-1:0]  cpu_wdata,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic           dn_valid,
  output logic           dn_io,
  output logic           dn_we,
  output logic [DAW-1:0] dn_addr,
  output logic [1:0]     dn_size,
  output logic [DW-1:0]  dn_wdata,
  input  logic           dn_done,
  input  logic [DW-1:0]  dn_rdata
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e         state;
  region_e        region;
  logic           legal, is_data, accept, reg_wr;
  logic [DAW-1:0] addr_raw;
  logic [DW-1:0]  reg_rd, wr_lanes, rd_lanes;

  cfgio_decode #(.AW(AW)) u_dec (
    .addr(cpu_addr), .size(cpu_size),
    .region(region), .legal(legal), .is_data(is_data)
  );

  assign cpu_ready = (state == ST_IDLE);
  assign accept    = cpu_valid && cpu_ready;
  assign reg_wr    = accept && legal && !is_data && cpu_we;

  cfgio_regs #(.DW(DW), .DAW(DAW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .region(region),
    .wdata(cpu_wdata), .addr_raw(addr_raw), .rd_data(reg_rd)
  );

  cfgio_lanes #(.DW(DW)) u_wr_lanes (
    .din(cpu_wdata), .size(cpu_size), .swap(region == RG_IODATA), .dout(wr_lanes)
  );

  cfgio_lanes #(.DW(DW)) u_rd_lanes (
    .din(dn_rdata), .size(dn_size), .swap(dn_io), .dout(rd_lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      dn_valid  <= 1'b0;
      dn_io     <= 1'b0;
      dn_we     <= 1'b0;
      dn_addr   <= '0;
      dn_size   <= SZ1;
      dn_wdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      dn_valid  <= 1'b0;
      if (state == ST_WAIT) begin
        if (dn_done) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= rd_lanes;
          state     <= ST_IDLE;
        end
      end else if (accept) begin
        if (!legal) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_rdata <= '0;
        end else if (is_data) begin
          dn_valid <= 1'b1;
          dn_io    <= (region == RG_IODATA);
          dn_we    <= cpu_we;
          dn_addr  <= {addr_raw[DAW-1:2], cpu_addr[1:0]};
          dn_size  <= cpu_size;
          dn_wdata <= cpu_we ? wr_lanes : '0;
          if (cpu_we) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
          end else begin
            state <= ST_WAIT;
          end
        end else begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= cpu_we ? '0 : reg_rd;
        end
      end
    end
  end

  // R4: an errored access never reaches the downstream side
  a_r4_err_quiet: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> !dn_valid);

  // R4: every downstream request is naturally aligned
  a_r4_dn_natural: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (dn_size != 2'd3) && !(dn_size == SZ2 && dn_addr[0]) &&
                 !(dn_size == SZ4 && dn_addr[1:0] != 2'd0));

  // R3: downstream address tracks the stored address above bit 1
  a_r3_base_match: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> dn_addr[DAW-1:2] == addr_raw[DAW-1:2]);

  // R9: a pending read blocks new accesses
  a_r9_wait_block: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_we) |-> !cpu_ready);

  // R9: returned data is answered on the next cycle
  a_r9_done_answers: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && dn_done) |=> (rsp_valid && !rsp_err && cpu_ready));
endmodule

// File: tb/tb_cfgio_port.sv
module tb_cfgio_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, rsp_valid, rsp_err, dn_valid, dn_io, dn_we;
  logic [31:0] rsp_rdata, dn_addr, dn_wdata;
  logic [1:0]  dn_size;
  logic        dn_done = 1'b0;
  logic [31:0] dn_rdata = '0;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  cfgio_port dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_wdata(cpu_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .dn_io(dn_io), .dn_we(dn_we),
    .dn_addr(dn_addr), .dn_size(dn_size), .dn_wdata(dn_wdata),
    .dn_done(dn_done), .dn_rdata(dn_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] shape(input logic [31:0] d, input int sz, input bit sw);
    int n;
    logic [31:0] r;
    n = 1 << sz;
    r = '0;
    for (int i = 0; i < n; i++)
      r[8*i +: 8] = sw ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
    return r;
  endfunction

  // Observed results of the last access
  logic        o_err, o_dnv, o_dnio, o_rspv;
  logic [31:0] o_rdata, o_dnaddr, o_dnwdata;
  logic [1:0]  o_dnsize;

  task automatic acc(input bit we, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input logic [31:0] rv);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
    o_dnv = dn_valid; o_dnio = dn_io; o_dnaddr = dn_addr;
    o_dnsize = dn_size; o_dnwdata = dn_wdata;
    o_rspv = rsp_valid; o_err = rsp_err; o_rdata = rsp_rdata;
    if (dn_valid && !dn_we) begin
      chk("R9 ready low while read pending", 32'(cpu_ready), 32'd0);
      chk("R9 no response before dn_done", 32'(rsp_valid), 32'd0);
      dn_done = 1'b1; dn_rdata = rv;
      @(negedge clk);
      dn_done = 1'b0;
      o_rspv = rsp_valid; o_err = rsp_err; o_rdata = rsp_rdata;
      chk("R9 ready back after read", 32'(cpu_ready), 32'd1);
    end
    chk("R9 response one cycle after accept or done", 32'(o_rspv), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready after reset", 32'(cpu_ready), 32'd1);
    acc(0, 8'h00, 2'd2, 0, 0); chk("R10 addr reg reset", o_rdata, 32'h0);
    acc(0, 8'h0C, 2'd2, 0, 0); chk("R10 fbb reset", o_rdata, 32'h0);
    acc(0, 8'h10, 2'd2, 0, 0); chk("R7 toc reset", o_rdata, 32'hFFFA0030);
    acc(0, 8'h14, 2'd2, 0, 0); chk("R10 arb reset", o_rdata, 32'h0);
    acc(0, 8'h18, 2'd2, 0, 0); chk("R10 lat reset", o_rdata, 32'h0);

    // R1 raw value kept
    acc(1, 8'h00, 2'd2, 32'h8000_1237, 0); chk("R1 write ok", 32'(o_err), 0);
    acc(0, 8'h00, 2'd2, 0, 0);             chk("R1 raw readback", o_rdata, 32'h8000_1237);

    // R2 illegal address-register accesses
    for (int off = 0; off < 4; off++)
      for (int sz = 0; sz < 4; sz++) begin
        if (off == 0 && sz == 2) continue;
        acc(1, 8'(off), 2'(sz), 32'h1111_1111, 0);
        chk("R2 addr reg bad access errors", 32'(o_err), 32'd1);
      end
    acc(0, 8'h00, 2'd2, 0, 0); chk("R2 addr reg unchanged", o_rdata, 32'h8000_1237);

    // R3/R4/R5 data port sweep
    for (int port = 0; port < 2; port++)
      for (int off = 0; off < 4; off++)
        for (int sz = 0; sz < 4; sz++)
          for (int we = 0; we < 2; we++) begin
            logic [31:0] wd, rv;
            bit ok;
            bit io;
            io = (port == 1);
            wd = 32'hA1B2_C3D4 ^ 32'(off * 32'h0101_0101);
            rv = 32'h1E2D_3C4B ^ 32'(sz * 32'h1010_1010);
            ok = (sz == 0) || (sz == 1 && off[0] == 1'b0) || (sz == 2 && off == 0);
            acc(we[0], 8'(8'h04 + port * 4 + off), 2'(sz), wd, rv);
            chk("R4 error flag vs offset/size", 32'(o_err), 32'(!ok));
            chk("R4 downstream request only when legal", 32'(o_dnv), 32'(ok));
            if (ok) begin
              chk("R3 downstream address", o_dnaddr, 32'h8000_1234 | 32'(off));
              chk("R3 downstream kind", 32'(o_dnio), 32'(io));
              chk("R3 downstream size", 32'(o_dnsize), 32'(sz));
              if (we) chk(io ? "R5 io write byte order" : "R3 cfg write no reorder",
                          o_dnwdata, shape(wd, sz, io));
              else    chk(io ? "R5 io read byte order" : "R3 cfg read no reorder",
                          o_rdata, shape(rv, sz, io));
            end
          end

    acc(0, 8'h1C, 2'd2, 0, 0); chk("R4 unmapped errors", 32'(o_err), 32'd1);
    chk("R4 unmapped no request", 32'(o_dnv), 32'd0);

    // R6 fbb
    acc(1, 8'h0C, 2'd2, 32'hFFFF_FFFF, 0);
    acc(0, 8'h0C, 2'd2, 0, 0); chk("R6 fbb keeps two bits", o_rdata, 32'h3);
    acc(1, 8'h0C, 2'd2, 32'h0000_0006, 0);
    acc(0, 8'h0C, 2'd2, 0, 0); chk("R6 fbb pattern", o_rdata, 32'h2);

    // R7 toc
    acc(1, 8'h10, 2'd2, 32'hFFFF_FFFF, 0);
    acc(0, 8'h10, 2'd2, 0, 0); chk("R7 toc all ones", o_rdata, 32'hFFFB_E030);
    acc(1, 8'h10, 2'd2, 32'h0000_2000, 0);
    acc(0, 8'h10, 2'd2, 0, 0); chk("R7 toc bit13", o_rdata, 32'hFFFA_2030);

    // R8 hardwired zeros
    acc(1, 8'h14, 2'd2, 32'hFFFF_FFFF, 0);
    acc(0, 8'h14, 2'd2, 0, 0); chk("R8 arb bit0 zero", o_rdata, 32'hFFFF_FFFE);
    acc(1, 8'h18, 2'd2, 32'hFFFF_FFFF, 0);
    acc(0, 8'h18, 2'd2, 0, 0); chk("R8 lat low bits zero", o_rdata, 32'hFFFF_FFF8);
    acc(1, 8'h18, 2'd2, 32'h0000_00F5, 0);
    acc(0, 8'h18, 2'd2, 0, 0); chk("R8 lat pattern", o_rdata, 32'h0000_00F0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule